// File: doc/BRIEF.md
# USB Host Subsystem Configuration Register File

This block holds the configuration and debug state of a USB host subsystem and presents it through three separately selected address windows: a 4 KB window for the transceiver-less link, a 1 KB window for the host wrapper, and a 1 KB window for controller vendor registers. All three windows share one address, size and write-data bus. Each window has its own select input, and a single access is expected per cycle. If more than one select is high, the link window wins, then the wrapper window.

Each storage register keeps only the bits its write mask allows. Identification and status locations return fixed values and ignore writes. Setting the soft-reset bit in the wrapper configuration word returns the wrapper and link registers to their defaults, and those defaults override the value carried by that same write. Only full 32-bit accesses are served. A narrower access, or an access to an offset that a window does not decode, reads zero, has no effect, and raises a one-cycle error strobe. Read data and the error strobe are registered and appear in the cycle after the access.

Top module: `usbh_cfg_regs`

## Requirements
- R1: After reset, `rdata_o` and `err_o` are 0, and the storage registers hold these values: wrapper config 0x1, host config 0x700, debug 0x20, link config 0x1, vendor ULPI word 0x0.
- R2: In the wrapper window, offset 0x000 reads 0x10 and offset 0x014 reads 0x7. Writes to either offset are discarded without an error.
- R3: The wrapper config register at offset 0x010 stores `wdata_i & 0x311D`.
- R4: A word write to wrapper offset 0x010 with bit 1 set returns wrapper config, host config, debug and link config to their R1 values, whatever the other bits of the write are. The vendor ULPI word keeps its value.
- R5: The host config register at wrapper offset 0x040 stores `wdata_i & 0x1F3D`.
- R6: The debug register at wrapper offset 0x044 stores `wdata_i & 0x000F00FF`.
- R7: In the vendor window, offset 0x0A4 stores only bits 31:28 of a write and returns them with the low bits zero. Every other offset in that window reads 0, ignores writes and raises no error.
- R8: In the link window, offset 0x000 reads 0x1 and offset 0x014 reads 0x1. Offsets 0x018 and 0x01C read 0.
- R9: The link config register at link offset 0x010 stores `wdata_i & 0xFFFFFEE0`.
- R10: An access whose `size_i` is not 2'b10 (the codes are 00 byte, 01 halfword, 10 word) reads 0, leaves every register unchanged and pulses `err_o` for one cycle.
- R11: An access to a wrapper or link offset not listed in R2 to R9, including offsets that are not word aligned, reads 0, changes nothing and pulses `err_o` for one cycle.
- R12: `rdata_o` and `err_o` change one clock after the access. `rdata_o` is 0 after a write or an idle cycle, and `err_o` is 0 after an idle cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tll_sel_i | input | 1 | Selects the link window for this cycle |
| wrap_sel_i | input | 1 | Selects the host wrapper window for this cycle |
| vend_sel_i | input | 1 | Selects the vendor register window for this cycle |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | 12 | Byte offset inside the selected window |
| size_i | input | 2 | Access size: 00 byte, 01 halfword, 10 word |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Registered read data |
| err_o | output | 1 | One-cycle strobe for a bad-width or unmapped access |

## Verification
Two functions can act at the same clock edge: the soft reset and the masked store into the wrapper config register. The bench provokes this with one word write that sets bit 1 together with every storable bit. It then reads back the default value rather than the masked value, and reads the host config, debug and link config registers to confirm they returned to their defaults as well. A second collision pairs a soft-reset value with a byte-wide size. Here the width check must win: the bench confirms that a register changed just before keeps its contents.

// File: rtl/usbh_cfg_pkg.sv
package usbh_cfg_pkg;
  localparam int unsigned DATA_W  = 32;
  localparam int unsigned ADDR_W  = 12;
  localparam int unsigned SIZE_W  = 2;
  localparam int unsigned TLL_AW  = 12;
  localparam int unsigned WRAP_AW = 10;
  localparam int unsigned VEND_AW = 10;
  localparam int unsigned SRST_BIT = 1;

  localparam logic [SIZE_W-1:0] SIZE_WORD = 2'b10;

  // window offsets
  localparam logic [ADDR_W-1:0] WRP_REV_OFS  = 12'h000;
  localparam logic [ADDR_W-1:0] WRP_SYS_OFS  = 12'h010;
  localparam logic [ADDR_W-1:0] WRP_STAT_OFS = 12'h014;
  localparam logic [ADDR_W-1:0] WRP_HCFG_OFS = 12'h040;
  localparam logic [ADDR_W-1:0] WRP_DBG_OFS  = 12'h044;
  localparam logic [ADDR_W-1:0] VND_ULPI_OFS = 12'h0A4;
  localparam logic [ADDR_W-1:0] TLL_REV_OFS  = 12'h000;
  localparam logic [ADDR_W-1:0] TLL_SYS_OFS  = 12'h010;
  localparam logic [ADDR_W-1:0] TLL_STAT_OFS = 12'h014;
  localparam logic [ADDR_W-1:0] TLL_IRQS_OFS = 12'h018;
  localparam logic [ADDR_W-1:0] TLL_IRQE_OFS = 12'h01C;

  // constant read values
  localparam logic [DATA_W-1:0] WRP_REV_VAL  = 32'h0000_0010;
  localparam logic [DATA_W-1:0] WRP_STAT_VAL = 32'h0000_0007;
  localparam logic [DATA_W-1:0] TLL_REV_VAL  = 32'h0000_0001;
  localparam logic [DATA_W-1:0] TLL_STAT_VAL = 32'h0000_0001;

  // defaults and write masks
  localparam logic [DATA_W-1:0] WRP_SYS_DEF  = 32'h0000_0001;
  localparam logic [DATA_W-1:0] WRP_SYS_MSK  = 32'h0000_311D;
  localparam logic [DATA_W-1:0] WRP_HCFG_DEF = 32'h0000_0700;
  localparam logic [DATA_W-1:0] WRP_HCFG_MSK = 32'h0000_1F3D;
  localparam logic [DATA_W-1:0] WRP_DBG_DEF  = 32'h0000_0020;
  localparam logic [DATA_W-1:0] WRP_DBG_MSK  = 32'h000F_00FF;
  localparam logic [DATA_W-1:0] VND_ULPI_DEF = 32'h0000_0000;
  localparam logic [DATA_W-1:0] VND_ULPI_MSK = 32'hF000_0000;
  localparam logic [DATA_W-1:0] TLL_SYS_DEF  = 32'h0000_0001;
  localparam logic [DATA_W-1:0] TLL_SYS_MSK  = 32'hFFFF_FEE0;

  typedef enum logic [3:0] {
    REG_NONE,
    REG_W_REV, REG_W_SYS, REG_W_STAT, REG_W_HCFG, REG_W_DBG,
    REG_V_ULPI, REG_V_ZERO,
    REG_T_REV, REG_T_SYS, REG_T_STAT, REG_T_IRQS, REG_T_IRQE
  } reg_id_e;
endpackage

// File: rtl/usbh_cfg_decode.sv
module usbh_cfg_decode
  import usbh_cfg_pkg::*;
(
  input  logic              tll_sel_i,
  input  logic              wrap_sel_i,
  input  logic              vend_sel_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [SIZE_W-1:0] size_i,
  output logic              act_o,
  output logic              bad_o,
  output reg_id_e           id_o
);
  logic [TLL_AW-1:0]  tll_ofs;
  logic [WRAP_AW-1:0] wrap_ofs;
  logic [VEND_AW-1:0] vend_ofs;

  assign tll_ofs  = addr_i[TLL_AW-1:0];
  assign wrap_ofs = addr_i[WRAP_AW-1:0];
  assign vend_ofs = addr_i[VEND_AW-1:0];
  assign act_o    = tll_sel_i | wrap_sel_i | vend_sel_i;

  always_comb begin
    id_o  = REG_NONE;
    bad_o = 1'b0;
    if (tll_sel_i) begin
      unique case (tll_ofs)
        TLL_AW'(TLL_REV_OFS):  id_o = REG_T_REV;
        TLL_AW'(TLL_SYS_OFS):  id_o = REG_T_SYS;
        TLL_AW'(TLL_STAT_OFS): id_o = REG_T_STAT;
        TLL_AW'(TLL_IRQS_OFS): id_o = REG_T_IRQS;
        TLL_AW'(TLL_IRQE_OFS): id_o = REG_T_IRQE;
        default:               bad_o = 1'b1;
      endcase
    end else if (wrap_sel_i) begin
      unique case (wrap_ofs)
        WRAP_AW'(WRP_REV_OFS):  id_o = REG_W_REV;
        WRAP_AW'(WRP_SYS_OFS):  id_o = REG_W_SYS;
        WRAP_AW'(WRP_STAT_OFS): id_o = REG_W_STAT;
        WRAP_AW'(WRP_HCFG_OFS): id_o = REG_W_HCFG;
        WRAP_AW'(WRP_DBG_OFS):  id_o = REG_W_DBG;
        default:                bad_o = 1'b1;
      endcase
    end else if (vend_sel_i) begin
      // whole vendor window is decoded: unknown offsets read zero
      id_o = (vend_ofs == VEND_AW'(VND_ULPI_OFS)) ? REG_V_ULPI : REG_V_ZERO;
    end
    if (act_o && (size_i != SIZE_WORD)) begin
      bad_o = 1'b1;
      id_o  = REG_NONE;
    end
  end
endmodule

// File: rtl/usbh_cfg_mreg.sv
module usbh_cfg_mreg #(
  parameter int unsigned W        = 32,
  parameter logic [W-1:0] RST_VAL = '0,
  parameter logic [W-1:0] WR_MASK = '1,
  parameter bit           SOFT_EN = 1'b1
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         we_i,
  input  logic         srst_i,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic srst_eff;

  // soft reset outranks the write that raised it
  assign srst_eff = SOFT_EN ? srst_i : 1'b0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       q_o <= RST_VAL;
    else if (srst_eff) q_o <= RST_VAL;
    else if (we_i)     q_o <= d_i & WR_MASK;
  end
endmodule

// File: rtl/usbh_cfg_regs.sv
module usbh_cfg_regs
  import usbh_cfg_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tll_sel_i,
  input  logic              wrap_sel_i,
  input  logic              vend_sel_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [SIZE_W-1:0] size_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              err_o
);
  localparam int unsigned NREG = 5;
  localparam int unsigned I_WSYS = 0, I_HCFG = 1, I_DBG = 2, I_ULPI = 3, I_TSYS = 4;
  localparam logic [NREG-1:0][DATA_W-1:0] DEFS  =
    {TLL_SYS_DEF, VND_ULPI_DEF, WRP_DBG_DEF, WRP_HCFG_DEF, WRP_SYS_DEF};
  localparam logic [NREG-1:0][DATA_W-1:0] MASKS =
    {TLL_SYS_MSK, VND_ULPI_MSK, WRP_DBG_MSK, WRP_HCFG_MSK, WRP_SYS_MSK};
  localparam logic [NREG-1:0] SOFTS = 5'b10111;
  localparam reg_id_e IDS [NREG] = '{REG_W_SYS, REG_W_HCFG, REG_W_DBG, REG_V_ULPI, REG_T_SYS};

  logic              act, bad, wr, rd, soft_rst;
  reg_id_e           id;
  logic [DATA_W-1:0] rd_val;
  logic [NREG-1:0][DATA_W-1:0] q;
  logic [DATA_W-1:0] wsys_q, hcfg_q, dbg_q, ulpi_q, tsys_q;

  usbh_cfg_decode u_dec (
    .tll_sel_i  (tll_sel_i),
    .wrap_sel_i (wrap_sel_i),
    .vend_sel_i (vend_sel_i),
    .addr_i     (addr_i),
    .size_i     (size_i),
    .act_o      (act),
    .bad_o      (bad),
    .id_o       (id)
  );

  assign wr       = act & we_i & ~bad;
  assign rd       = act & ~we_i & ~bad;
  assign soft_rst = wr & (id == REG_W_SYS) & wdata_i[SRST_BIT];

  for (genvar g = 0; g < NREG; g++) begin : g_reg
    usbh_cfg_mreg #(
      .W       (DATA_W),
      .RST_VAL (DEFS[g]),
      .WR_MASK (MASKS[g]),
      .SOFT_EN (SOFTS[g])
    ) u_reg (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .we_i   (wr && (id == IDS[g])),
      .srst_i (soft_rst),
      .d_i    (wdata_i),
      .q_o    (q[g])
    );
  end

  assign wsys_q = q[I_WSYS];
  assign hcfg_q = q[I_HCFG];
  assign dbg_q  = q[I_DBG];
  assign ulpi_q = q[I_ULPI];
  assign tsys_q = q[I_TSYS];

  always_comb begin
    unique case (id)
      REG_W_REV:  rd_val = WRP_REV_VAL;
      REG_W_STAT: rd_val = WRP_STAT_VAL;
      REG_W_SYS:  rd_val = wsys_q;
      REG_W_HCFG: rd_val = hcfg_q;
      REG_W_DBG:  rd_val = dbg_q;
      REG_V_ULPI: rd_val = ulpi_q;
      REG_T_REV:  rd_val = TLL_REV_VAL;
      REG_T_STAT: rd_val = TLL_STAT_VAL;
      REG_T_SYS:  rd_val = tsys_q;
      default:    rd_val = '0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rdata_o <= '0;
      err_o   <= 1'b0;
    end else begin
      rdata_o <= rd ? rd_val : '0;
      err_o   <= act & bad;
    end
  end
endmodule

// File: rtl/usbh_cfg_regs_chk.sv
module usbh_cfg_regs_chk
  import usbh_cfg_pkg::*;
(
  input logic              clk_i,
  input logic              rst_ni,
  input logic [2:0]        sel_i,
  input logic [SIZE_W-1:0] size_i,
  input logic [DATA_W-1:0] rdata_o,
  input logic              err_o,
  input logic              soft_rst,
  input logic [DATA_W-1:0] wsys_q,
  input logic [DATA_W-1:0] hcfg_q,
  input logic [DATA_W-1:0] dbg_q,
  input logic [DATA_W-1:0] ulpi_q,
  input logic [DATA_W-1:0] tsys_q
);
  p_wsys_mask_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wsys_q & ~WRP_SYS_MSK) == '0);

  p_soft_dflt_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    soft_rst |=> (wsys_q == WRP_SYS_DEF && hcfg_q == WRP_HCFG_DEF &&
                  dbg_q == WRP_DBG_DEF && tsys_q == TLL_SYS_DEF));

  p_hcfg_mask_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hcfg_q & ~WRP_HCFG_MSK) == '0);

  p_dbg_mask_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dbg_q & ~WRP_DBG_MSK) == '0);

  p_ulpi_low_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ulpi_q & ~VND_ULPI_MSK) == '0);

  p_tsys_mask_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tsys_q & ~(TLL_SYS_MSK | TLL_SYS_DEF)) == '0);

  p_width_err_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((|sel_i) && size_i != SIZE_WORD) |=> err_o);

  p_err_hold_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> ($stable(wsys_q) && $stable(hcfg_q) && $stable(dbg_q) &&
               $stable(ulpi_q) && $stable(tsys_q)));

  p_err_zero_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> rdata_o == '0);

  p_idle_quiet_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(|sel_i) |=> (rdata_o == '0 && !err_o));
endmodule

bind usbh_cfg_regs usbh_cfg_regs_chk u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .sel_i    ({vend_sel_i, wrap_sel_i, tll_sel_i}),
  .size_i   (size_i),
  .rdata_o  (rdata_o),
  .err_o    (err_o),
  .soft_rst (soft_rst),
  .wsys_q   (wsys_q),
  .hcfg_q   (hcfg_q),
  .dbg_q    (dbg_q),
  .ulpi_q   (ulpi_q),
  .tsys_q   (tsys_q)
);

// File: tb/usbh_cfg_regs_tb.sv
module usbh_cfg_regs_tb;
  localparam logic [2:0] T = 3'b001, W = 3'b010, V = 3'b100, N = 3'b000;
  localparam logic [1:0] SB = 2'b00, SH = 2'b01, SW = 2'b10;

  typedef struct packed {
    logic [2:0]  sel;
    logic        we;
    logic [11:0] addr;
    logic [1:0]  size;
    logic [31:0] wdata;
    logic [31:0] exp_rd;
    logic        exp_err;
    logic [3:0]  req;
  } vec_t;

  localparam int NV = 38;
  localparam vec_t VEC [NV] = '{
    '{W, 1'b0, 12'h000, SW, 32'h0,        32'h10,       1'b0, 4'd2},  // R2
    '{W, 1'b0, 12'h014, SW, 32'h0,        32'h7,        1'b0, 4'd2},
    '{W, 1'b1, 12'h000, SW, 32'hFFFFFFFF, 32'h0,        1'b0, 4'd2},
    '{W, 1'b1, 12'h014, SW, 32'hFFFFFFFF, 32'h0,        1'b0, 4'd2},
    '{W, 1'b0, 12'h000, SW, 32'h0,        32'h10,       1'b0, 4'd2},
    '{W, 1'b0, 12'h014, SW, 32'h0,        32'h7,        1'b0, 4'd2},
    '{W, 1'b1, 12'h010, SW, 32'hFFFFFFFD, 32'h0,        1'b0, 4'd3},  // R3
    '{W, 1'b0, 12'h010, SW, 32'h0,        32'h311D,     1'b0, 4'd3},
    '{W, 1'b1, 12'h040, SW, 32'hFFFFFFFF, 32'h0,        1'b0, 4'd5},  // R5
    '{W, 1'b0, 12'h040, SW, 32'h0,        32'h1F3D,     1'b0, 4'd5},
    '{W, 1'b1, 12'h044, SW, 32'h12345678, 32'h0,        1'b0, 4'd6},  // R6
    '{W, 1'b0, 12'h044, SW, 32'h0,        32'h00040078, 1'b0, 4'd6},
    '{V, 1'b1, 12'h0A4, SW, 32'hABCDEF01, 32'h0,        1'b0, 4'd7},  // R7
    '{V, 1'b0, 12'h0A4, SW, 32'h0,        32'hA0000000, 1'b0, 4'd7},
    '{V, 1'b0, 12'h0A0, SW, 32'h0,        32'h0,        1'b0, 4'd7},
    '{V, 1'b1, 12'h010, SW, 32'hFFFFFFFF, 32'h0,        1'b0, 4'd7},
    '{V, 1'b0, 12'h010, SW, 32'h0,        32'h0,        1'b0, 4'd7},
    '{V, 1'b0, 12'h0A4, SW, 32'h0,        32'hA0000000, 1'b0, 4'd7},
    '{T, 1'b0, 12'h000, SW, 32'h0,        32'h1,        1'b0, 4'd8},  // R8
    '{T, 1'b0, 12'h014, SW, 32'h0,        32'h1,        1'b0, 4'd8},
    '{T, 1'b0, 12'h018, SW, 32'h0,        32'h0,        1'b0, 4'd8},
    '{T, 1'b0, 12'h01C, SW, 32'h0,        32'h0,        1'b0, 4'd8},
    '{T, 1'b1, 12'h010, SW, 32'hFFFFFFFF, 32'h0,        1'b0, 4'd9},  // R9
    '{T, 1'b0, 12'h010, SW, 32'h0,        32'hFFFFFEE0, 1'b0, 4'd9},
    '{W, 1'b1, 12'h010, SB, 32'h00000002, 32'h0,        1'b1, 4'd10}, // R10
    '{W, 1'b0, 12'h044, SW, 32'h0,        32'h00040078, 1'b0, 4'd10},
    '{T, 1'b0, 12'h010, SH, 32'h0,        32'h0,        1'b1, 4'd10},
    '{W, 1'b1, 12'h048, SW, 32'hFF,       32'h0,        1'b1, 4'd11}, // R11
    '{W, 1'b0, 12'h020, SW, 32'h0,        32'h0,        1'b1, 4'd11},
    '{W, 1'b0, 12'h012, SW, 32'h0,        32'h0,        1'b1, 4'd11},
    '{T, 1'b0, 12'h020, SW, 32'h0,        32'h0,        1'b1, 4'd11},
    '{N, 1'b0, 12'h010, SW, 32'h0,        32'h0,        1'b0, 4'd12}, // R12
    '{W, 1'b1, 12'h010, SW, 32'h0000311F, 32'h0,        1'b0, 4'd4},  // R4
    '{W, 1'b0, 12'h010, SW, 32'h0,        32'h1,        1'b0, 4'd4},
    '{W, 1'b0, 12'h040, SW, 32'h0,        32'h700,      1'b0, 4'd4},
    '{W, 1'b0, 12'h044, SW, 32'h0,        32'h20,       1'b0, 4'd4},
    '{T, 1'b0, 12'h010, SW, 32'h0,        32'h1,        1'b0, 4'd4},
    '{V, 1'b0, 12'h0A4, SW, 32'h0,        32'hA0000000, 1'b0, 4'd4}
  };

  logic        clk_i = 1'b0, rst_ni = 1'b0;
  logic        tll_sel_i = 1'b0, wrap_sel_i = 1'b0, vend_sel_i = 1'b0, we_i = 1'b0;
  logic [11:0] addr_i = '0;
  logic [1:0]  size_i = SW;
  logic [31:0] wdata_i = '0;
  logic [31:0] rdata_o;
  logic        err_o;
  int          checks = 0, errors = 0;
  bit          done = 1'b0;

  always #10 clk_i = ~clk_i;

  usbh_cfg_regs u_dut (
    .clk_i (clk_i), .rst_ni (rst_ni),
    .tll_sel_i (tll_sel_i), .wrap_sel_i (wrap_sel_i), .vend_sel_i (vend_sel_i),
    .we_i (we_i), .addr_i (addr_i), .size_i (size_i), .wdata_i (wdata_i),
    .rdata_o (rdata_o), .err_o (err_o)
  );

  task automatic check(input int req, input logic [31:0] rd, input logic er,
                       input logic [31:0] exp_rd, input logic exp_er);
    checks++;
    if (rd !== exp_rd || er !== exp_er) begin
      errors++;
      $display("FAIL R%0d: rdata=%h err=%b expected rdata=%h err=%b",
               req, rd, er, exp_rd, exp_er);
    end
  endtask

  // drive at a falling edge, return at the next falling edge (output registered)
  task automatic access(input logic [2:0] sel, input logic we, input logic [11:0] addr,
                        input logic [1:0] size, input logic [31:0] wd);
    {vend_sel_i, wrap_sel_i, tll_sel_i} = sel;
    we_i = we; addr_i = addr; size_i = size; wdata_i = wd;
    @(negedge clk_i);
  endtask

  initial begin
    #(20 * 200000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: run did not finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk_i);
    check(1, rdata_o, err_o, 32'h0, 1'b0);  // R1 outputs under reset
    rst_ni = 1'b1;
    @(negedge clk_i);

    for (int i = 0; i < NV; i++) begin
      access(VEC[i].sel, VEC[i].we, VEC[i].addr, VEC[i].size, VEC[i].wdata);
      check(int'(VEC[i].req), rdata_o, err_o, VEC[i].exp_rd, VEC[i].exp_err);
    end

    // R12: data valid exactly one cycle, then zero after idle
    access(W, 1'b0, 12'h040, SW, 32'h0);
    check(12, rdata_o, err_o, 32'h700, 1'b0);
    access(N, 1'b0, 12'h040, SW, 32'h0);
    check(12, rdata_o, err_o, 32'h0, 1'b0);
    // R12: error strobe lasts one cycle
    access(T, 1'b0, 12'h100, SW, 32'h0);
    check(12, rdata_o, err_o, 32'h0, 1'b1);
    access(N, 1'b0, 12'h000, SW, 32'h0);
    check(12, rdata_o, err_o, 32'h0, 1'b0);

    // R1: reset mid-run, then all defaults including the vendor word
    access(W, 1'b1, 12'h040, SW, 32'hFFFFFFFF);
    access(N, 1'b0, 12'h000, SW, 32'h0);
    rst_ni = 1'b0;
    @(negedge clk_i);
    check(1, rdata_o, err_o, 32'h0, 1'b0);
    rst_ni = 1'b1;
    @(negedge clk_i);
    access(W, 1'b0, 12'h010, SW, 32'h0); check(1, rdata_o, err_o, 32'h1,   1'b0);
    access(W, 1'b0, 12'h040, SW, 32'h0); check(1, rdata_o, err_o, 32'h700, 1'b0);
    access(W, 1'b0, 12'h044, SW, 32'h0); check(1, rdata_o, err_o, 32'h20,  1'b0);
    access(T, 1'b0, 12'h010, SW, 32'h0); check(1, rdata_o, err_o, 32'h1,   1'b0);
    access(V, 1'b0, 12'h0A4, SW, 32'h0); check(1, rdata_o, err_o, 32'h0,   1'b0);

    access(N, 1'b0, 12'h000, SW, 32'h0);
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule